// File: doc/BRIEF.md
# Read-Priority Cache Bus Controller

This block sits between two cache units, one holding instructions and one holding data, and a single external bus. Each cache can ask for a one-longword read, a one-longword write, a four-longword line fill, or a four-longword line write-back. The controller decides which request gets the bus and steps through each beat. The bus uses a per-beat acknowledge. Read data goes back only to the cache that asked for it.

Reads are served before writes so the fetch and operand paths are not kept waiting. A dirty line that is evicted is copied into a one-line holding buffer and acknowledged at once. The refill for the same miss can then use the bus first, and the buffer is written out later. Data-side accesses flagged as serialized I/O keep program order. The buffer is emptied before them, and no read gets ahead of them.

The sequencer has four states. `ST_IDLE` waits for a choice from the arbiter. `ST_READ` runs a single read or a line fill. `ST_WRITE` runs a single write. `ST_DRAIN` writes the held line back to memory. The transitions are:
- IDLE to READ, WRITE or DRAIN on a non-empty pick.
- Any active state stays put while the acknowledge is low.
- Any active state advances its beat on an acknowledge that is not the last one.
- Any active state returns to IDLE on the acknowledge of its last beat.

Top module: `cache_bus_ctrl`

## Requirements
- R1: After reset, bus_valid, i_done, d_done, i_rvalid and d_rvalid are all low.
- R2: A request with kind 2'b00 (single read) makes one bus beat with bus_burst low, at the requested longword address. The acknowledged data appears on that side's rdata with rvalid one cycle after the acknowledge, and done is high in that same cycle.
- R3: Kind 2'b10 (line fill) makes four read beats with bus_burst high. The beats start at the line base (address bits 3:0 zero) and rise by 4. The four words come back in beat order, and done is high with the fourth.
- R4: Kind 2'b01 (single write) makes one write beat (bus_we high) at the requested address, carrying the low longword of the wdata port. Done follows the acknowledge by one cycle.
- R5: Kind 2'b11 (write-back) is taken into the line buffer whenever the buffer is empty. Done is given the next cycle, before any bus beat for it. The line is later written as a four-beat write burst from the line base, with longword k taken from wdata bits 32k+31:32k.
- R6: When the bus is free, a pending read (either side) is started before a pending non-I/O single write and before draining the buffer.
- R7: When both sides have a read pending at the same time, the data side wins the first such tie, and later ties alternate between the sides.
- R8: Once a transfer has started, its beats run back to back with no beat of another transfer in between. Address and direction hold until each beat is acknowledged.
- R9: When the buffer holds a line and a pending request targets that same line, the buffer is drained before that request is issued.
- R10: A data-side request with d_io high is issued ahead of any read. If the buffer is full, the buffer is drained first.
- R11: Read data is returned only to the side that asked. i_rvalid and d_rvalid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Instruction-side request, held until done |
| i_kind | input | 2 | Instruction-side request kind |
| i_addr | input | AW | Instruction-side byte address |
| i_wdata | input | DW*BEATS | Instruction-side write line (low longword for single writes) |
| i_done | output | 1 | Instruction-side request complete (one cycle) |
| i_rvalid | output | 1 | Instruction-side read beat valid |
| i_rdata | output | DW | Instruction-side read data |
| d_req | input | 1 | Data-side request, held until done |
| d_kind | input | 2 | Data-side request kind |
| d_io | input | 1 | Data-side request is serialized I/O |
| d_addr | input | AW | Data-side byte address |
| d_wdata | input | DW*BEATS | Data-side write line (low longword for single writes) |
| d_done | output | 1 | Data-side request complete (one cycle) |
| d_rvalid | output | 1 | Data-side read beat valid |
| d_rdata | output | DW | Data-side read data |
| bus_valid | output | 1 | Beat in progress |
| bus_we | output | 1 | Beat is a write |
| bus_burst | output | 1 | Beat belongs to a four-beat burst |
| bus_addr | output | AW | Beat byte address |
| bus_wdata | output | DW | Beat write data |
| bus_ack | input | 1 | Beat accepted by memory |
| bus_rdata | input | DW | Read data, valid with bus_ack |

## Verification
The bench targets the orderings that a wrong design would break. In one case a held write-back and a read to the same line are pending together. If the controller let the read through first, it would return stale memory words, and the scoreboard would catch them. In another case an I/O write races an instruction read. A controller that applied plain read priority would put the read first on the bus. Two back-to-back read ties must go to opposite sides, and a controller without the alternation would serve the data side twice. A read that arrives in the middle of a line fill must wait until all four fill beats are done. A preempting controller would split the beat log.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [1:0] {
        K_RD   = 2'b00,
        K_WR   = 2'b01,
        K_FILL = 2'b10,
        K_WB   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_DRAIN,
        PK_INSTR,
        PK_DATA
    } pick_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DRAIN
    } state_e;

endpackage

// File: rtl/cbc_arbiter.sv
module cbc_arbiter
    import cbc_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             i_req,
    input  logic [1:0]       i_kind,
    input  logic [TAG_W-1:0] i_tag,
    input  logic             i_mask,
    input  logic             d_req,
    input  logic [1:0]       d_kind,
    input  logic             d_io,
    input  logic [TAG_W-1:0] d_tag,
    input  logic             d_mask,
    input  logic             buf_full,
    input  logic [TAG_W-1:0] buf_tag,
    output pick_e            pick
);

    logic i_act, d_act, i_rd, d_rd, i_wr, d_wr;
    logic d_ser, i_hit, d_hit, tie;
    logic tie_last_d;

    always_comb begin
        i_act = i_req && !i_mask && (i_kind != K_WB);
        d_act = d_req && !d_mask && (d_kind != K_WB);
        i_rd  = i_act && ((i_kind == K_RD) || (i_kind == K_FILL));
        d_rd  = d_act && ((d_kind == K_RD) || (d_kind == K_FILL));
        i_wr  = i_act && (i_kind == K_WR);
        d_wr  = d_act && (d_kind == K_WR);
        d_ser = d_act && d_io;
        i_hit = i_act && buf_full && (i_tag == buf_tag);
        d_hit = d_act && buf_full && (d_tag == buf_tag);
        tie   = i_rd && d_rd && !d_ser;
    end

    always_comb begin
        pick = PK_NONE;
        if (busy) begin
            pick = PK_NONE;
        end else if (buf_full && (i_hit || d_hit || d_ser)) begin
            pick = PK_DRAIN;
        end else if (d_ser) begin
            pick = PK_DATA;
        end else if (tie) begin
            pick = tie_last_d ? PK_INSTR : PK_DATA;
        end else if (d_rd) begin
            pick = PK_DATA;
        end else if (i_rd) begin
            pick = PK_INSTR;
        end else if (buf_full) begin
            pick = PK_DRAIN;
        end else if (d_wr) begin
            pick = PK_DATA;
        end else if (i_wr) begin
            pick = PK_INSTR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie_last_d <= 1'b0;
        end else if (!busy && tie && (pick == PK_DATA || pick == PK_INSTR)) begin
            tie_last_d <= (pick == PK_DATA);
        end
    end

    // R6: a non-I/O write from the data side never starts while a read waits
    a_r6_read_first : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && d_wr && !d_ser && (i_rd || d_rd)) |-> (pick != PK_DATA || d_rd));

endmodule

// File: rtl/cbc_wbbuf.sv
module cbc_wbbuf
    import cbc_pkg::*;
#(
    parameter int TAG_W  = 28,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_req,
    input  logic [1:0]        i_kind,
    input  logic [TAG_W-1:0]  i_tag,
    input  logic [LINE_W-1:0] i_wdata,
    input  logic              i_mask,
    input  logic              d_req,
    input  logic [1:0]        d_kind,
    input  logic [TAG_W-1:0]  d_tag,
    input  logic [LINE_W-1:0] d_wdata,
    input  logic              d_mask,
    input  logic              clear,
    output logic              full,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] line,
    output logic              take_i,
    output logic              take_d
);

    logic              full_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_comb begin
        take_d = !full_q && d_req && !d_mask && (d_kind == K_WB);
        take_i = !full_q && i_req && !i_mask && (i_kind == K_WB) && !take_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            tag_q  <= '0;
            line_q <= '0;
        end else if (clear) begin
            full_q <= 1'b0;
        end else if (take_d) begin
            full_q <= 1'b1;
            tag_q  <= d_tag;
            line_q <= d_wdata;
        end else if (take_i) begin
            full_q <= 1'b1;
            tag_q  <= i_tag;
            line_q <= i_wdata;
        end
    end

    assign full = full_q;
    assign tag  = tag_q;
    assign line = line_q;

    a_r5_line_held : assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !clear) |=> (full_q && $stable(line_q) && $stable(tag_q)));

    a_r5_clear_when_full : assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> full_q);

endmodule

// File: rtl/cbc_seq.sv
module cbc_seq
    import cbc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pick_e                pick,
    input  logic [1:0]           i_kind,
    input  logic [AW-$clog2(DW/8)-1:0] i_wa,
    input  logic [DW*BEATS-1:0]  i_wdata,
    input  logic [1:0]           d_kind,
    input  logic [AW-$clog2(DW/8)-1:0] d_wa,
    input  logic [DW*BEATS-1:0]  d_wdata,
    input  logic [AW-$clog2(DW/8)-$clog2(BEATS)-1:0] buf_tag,
    input  logic [DW*BEATS-1:0]  buf_line,
    input  logic                 bus_ack,
    input  logic [DW-1:0]        bus_rdata,
    output logic                 bus_valid,
    output logic                 bus_we,
    output logic                 bus_burst,
    output logic [AW-1:0]        bus_addr,
    output logic [DW-1:0]        bus_wdata,
    output logic                 busy,
    output logic                 beat_valid,
    output logic [DW-1:0]        beat_data,
    output logic                 xfer_done,
    output logic                 src_d,
    output logic                 drain_done
);

    localparam int BYTE_OFF = $clog2(DW / 8);
    localparam int BEAT_W   = $clog2(BEATS);
    localparam int WA_W     = AW - BYTE_OFF;
    localparam int TAG_W    = WA_W - BEAT_W;
    localparam int LINE_W   = DW * BEATS;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [AW-1:0]     STEP      = AW'(DW / 8);

    state_e              state, state_d;
    logic                src_d_q, burst_q;
    logic [TAG_W-1:0]    tag_q;
    logic [BEAT_W-1:0]   beat_q;
    logic [LINE_W-1:0]   wline_q;
    logic                last;

    logic [1:0]          sel_kind;
    logic [WA_W-1:0]     sel_wa;
    logic [LINE_W-1:0]   sel_line;
    logic                sel_read;

    always_comb begin
        sel_kind = (pick == PK_DATA) ? d_kind  : i_kind;
        sel_wa   = (pick == PK_DATA) ? d_wa    : i_wa;
        sel_line = (pick == PK_DATA) ? d_wdata : i_wdata;
        sel_read = (sel_kind == K_RD) || (sel_kind == K_FILL);
        last     = !burst_q || (beat_q == LAST_BEAT);
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                unique case (pick)
                    PK_DRAIN:         state_d = ST_DRAIN;
                    PK_INSTR, PK_DATA: state_d = sel_read ? ST_READ : ST_WRITE;
                    default:          state_d = ST_IDLE;
                endcase
            end
            ST_READ, ST_WRITE, ST_DRAIN: begin
                if (bus_ack && last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d_q <= 1'b0;
            burst_q <= 1'b0;
            tag_q   <= '0;
            beat_q  <= '0;
            wline_q <= '0;
        end else if (state == ST_IDLE) begin
            if (pick == PK_DRAIN) begin
                src_d_q <= 1'b0;
                burst_q <= 1'b1;
                tag_q   <= buf_tag;
                beat_q  <= '0;
                wline_q <= buf_line;
            end else if (pick != PK_NONE) begin
                src_d_q <= (pick == PK_DATA);
                burst_q <= (sel_kind == K_FILL);
                tag_q   <= sel_wa[WA_W-1:BEAT_W];
                beat_q  <= (sel_kind == K_FILL) ? '0 : sel_wa[BEAT_W-1:0];
                wline_q <= sel_line;
            end
        end else if (bus_ack && !last) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_valid  = (state != ST_IDLE);
        bus_we     = (state == ST_WRITE) || (state == ST_DRAIN);
        bus_burst  = burst_q;
        bus_addr   = {tag_q, beat_q, {BYTE_OFF{1'b0}}};
        bus_wdata  = burst_q ? wline_q[beat_q*DW +: DW] : wline_q[DW-1:0];
        busy       = (state != ST_IDLE);
        beat_valid = (state == ST_READ) && bus_ack;
        beat_data  = bus_rdata;
        xfer_done  = ((state == ST_READ) || (state == ST_WRITE)) && bus_ack && last;
        src_d      = src_d_q;
        drain_done = (state == ST_DRAIN) && bus_ack && last;
    end

    a_r8_beat_held : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

    a_r3_beat_step : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack && bus_burst && (beat_q != LAST_BEAT))
        |=> (bus_valid && bus_burst && (bus_addr == $past(bus_addr) + STEP)));

    a_r2_single_one_beat : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack && !bus_burst) |=> !bus_valid);

    a_r5_drain_is_write_burst : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (bus_we && bus_burst));

endmodule

// File: rtl/cache_bus_ctrl.sv
module cache_bus_ctrl
    import cbc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_req,
    input  logic [1:0]          i_kind,
    input  logic [AW-1:0]       i_addr,
    input  logic [DW*BEATS-1:0] i_wdata,
    output logic                i_done,
    output logic                i_rvalid,
    output logic [DW-1:0]       i_rdata,
    input  logic                d_req,
    input  logic [1:0]          d_kind,
    input  logic                d_io,
    input  logic [AW-1:0]       d_addr,
    input  logic [DW*BEATS-1:0] d_wdata,
    output logic                d_done,
    output logic                d_rvalid,
    output logic [DW-1:0]       d_rdata,
    output logic                bus_valid,
    output logic                bus_we,
    output logic                bus_burst,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       bus_wdata,
    input  logic                bus_ack,
    input  logic [DW-1:0]       bus_rdata
);

    localparam int LINE_W   = DW * BEATS;
    localparam int BYTE_OFF = $clog2(DW / 8);
    localparam int BEAT_W   = $clog2(BEATS);
    localparam int OFF_W    = BYTE_OFF + BEAT_W;
    localparam int TAG_W    = AW - OFF_W;

    pick_e             pick;
    logic              busy;
    logic              buf_full;
    logic [TAG_W-1:0]  buf_tag;
    logic [LINE_W-1:0] buf_line;
    logic              take_i, take_d;
    logic              beat_valid, xfer_done, src_d, drain_done;
    logic [DW-1:0]     beat_data;

    logic              i_done_q, d_done_q, i_rv_q, d_rv_q;
    logic [DW-1:0]     rdata_q;

    cbc_arbiter #(.TAG_W(TAG_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .i_req    (i_req),
        .i_kind   (i_kind),
        .i_tag    (i_addr[AW-1:OFF_W]),
        .i_mask   (i_done_q),
        .d_req    (d_req),
        .d_kind   (d_kind),
        .d_io     (d_io),
        .d_tag    (d_addr[AW-1:OFF_W]),
        .d_mask   (d_done_q),
        .buf_full (buf_full),
        .buf_tag  (buf_tag),
        .pick     (pick)
    );

    cbc_wbbuf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_wbbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_req   (i_req),
        .i_kind  (i_kind),
        .i_tag   (i_addr[AW-1:OFF_W]),
        .i_wdata (i_wdata),
        .i_mask  (i_done_q),
        .d_req   (d_req),
        .d_kind  (d_kind),
        .d_tag   (d_addr[AW-1:OFF_W]),
        .d_wdata (d_wdata),
        .d_mask  (d_done_q),
        .clear   (drain_done),
        .full    (buf_full),
        .tag     (buf_tag),
        .line    (buf_line),
        .take_i  (take_i),
        .take_d  (take_d)
    );

    cbc_seq #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick       (pick),
        .i_kind     (i_kind),
        .i_wa       (i_addr[AW-1:BYTE_OFF]),
        .i_wdata    (i_wdata),
        .d_kind     (d_kind),
        .d_wa       (d_addr[AW-1:BYTE_OFF]),
        .d_wdata    (d_wdata),
        .buf_tag    (buf_tag),
        .buf_line   (buf_line),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_burst  (bus_burst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .xfer_done  (xfer_done),
        .src_d      (src_d),
        .drain_done (drain_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_done_q <= 1'b0;
            d_done_q <= 1'b0;
            i_rv_q   <= 1'b0;
            d_rv_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            i_done_q <= (xfer_done && !src_d) || take_i;
            d_done_q <= (xfer_done &&  src_d) || take_d;
            i_rv_q   <= beat_valid && !src_d;
            d_rv_q   <= beat_valid &&  src_d;
            if (beat_valid) rdata_q <= beat_data;
        end
    end

    assign i_done   = i_done_q;
    assign d_done   = d_done_q;
    assign i_rvalid = i_rv_q;
    assign d_rvalid = d_rv_q;
    assign i_rdata  = rdata_q;
    assign d_rdata  = rdata_q;

    a_r11_one_side : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_rvalid, d_rvalid}));

    // R5: a taken write-back answers without a bus beat in the same cycle
    a_r5_quiet_take : assert property (@(posedge clk) disable iff (!rst_n)
        (take_i || take_d) |=> (i_done || d_done));

    // R9: the buffer is never drained while it is empty
    a_r9_drain_has_line : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pick == PK_DRAIN) |-> buf_full);

endmodule

// File: tb/cache_bus_ctrl_tb.sv
module cache_bus_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         i_req = 1'b0, d_req = 1'b0, d_io = 1'b0;
    logic [1:0]   i_kind = 2'b00, d_kind = 2'b00;
    logic [31:0]  i_addr = '0, d_addr = '0;
    logic [127:0] i_wdata = '0, d_wdata = '0;
    logic         i_done, d_done, i_rvalid, d_rvalid;
    logic [31:0]  i_rdata, d_rdata;
    logic         bus_valid, bus_we, bus_burst;
    logic [31:0]  bus_addr, bus_wdata;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_rdata = '0;

    always #4 clk = ~clk;

    cache_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_req(i_req), .i_kind(i_kind), .i_addr(i_addr), .i_wdata(i_wdata),
        .i_done(i_done), .i_rvalid(i_rvalid), .i_rdata(i_rdata),
        .d_req(d_req), .d_kind(d_kind), .d_io(d_io), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_done(d_done), .d_rvalid(d_rvalid), .d_rdata(d_rdata),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_burst(bus_burst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int ack_gap = 0;
    int wait_cnt = 0;

    logic [31:0] mem_bus [256];
    logic [31:0] gold [256];
    logic [31:0] exp_i [$];
    logic [31:0] exp_d [$];
    logic [32:0] blog [$];

    logic        we_s;
    logic [31:0] addr_s, wdata_s;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory model: answers beats, records order of acknowledged beats
    always @(negedge clk) begin
        if (bus_ack) begin
            blog.push_back({we_s, addr_s});
            if (we_s) mem_bus[addr_s[9:2]] = wdata_s;
        end
        if (bus_valid && wait_cnt >= ack_gap) begin
            bus_ack   = 1'b1;
            bus_rdata = mem_bus[bus_addr[9:2]];
            we_s      = bus_we;
            addr_s    = bus_addr;
            wdata_s   = bus_wdata;
            wait_cnt  = 0;
        end else begin
            bus_ack = 1'b0;
            if (bus_valid) wait_cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (i_rvalid && d_rvalid) chk(1'b0, "R11 both rvalid", 32'h3, 32'h1);
            if (i_rvalid) begin
                if (exp_i.size() == 0) chk(1'b0, "R11 unexpected i_rvalid", i_rdata, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_i.pop_front();
                    chk(i_rdata == e, "R2/R3 i read data", i_rdata, e);
                end
            end
            if (d_rvalid) begin
                if (exp_d.size() == 0) chk(1'b0, "R11 unexpected d_rvalid", d_rdata, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_d.pop_front();
                    chk(d_rdata == e, "R2/R3 d read data", d_rdata, e);
                end
            end
        end
    end

    task automatic do_req(input bit side, input logic [1:0] kind, input logic [31:0] addr,
                          input bit io, input logic [127:0] line);
        @(negedge clk);
        if (kind == 2'b00) begin
            if (side) exp_d.push_back(gold[addr[9:2]]); else exp_i.push_back(gold[addr[9:2]]);
        end else if (kind == 2'b10) begin
            for (int k = 0; k < 4; k++) begin
                if (side) exp_d.push_back(gold[{addr[9:4], 2'(k)}]);
                else      exp_i.push_back(gold[{addr[9:4], 2'(k)}]);
            end
        end else if (kind == 2'b01) begin
            gold[addr[9:2]] = line[31:0];
        end else begin
            for (int k = 0; k < 4; k++) gold[{addr[9:4], 2'(k)}] = line[k*32 +: 32];
        end
        if (side) begin
            d_kind = kind; d_addr = addr; d_io = io; d_wdata = line; d_req = 1'b1;
        end else begin
            i_kind = kind; i_addr = addr; i_wdata = line; i_req = 1'b1;
        end
        do @(negedge clk); while (!(side ? d_done : i_done));
        if (side) begin d_req = 1'b0; d_io = 1'b0; end
        else i_req = 1'b0;
    endtask

    task automatic settle();
        int quiet;
        quiet = 0;
        while (quiet < 6) begin
            @(negedge clk);
            if (bus_valid || bus_ack) quiet = 0; else quiet++;
        end
    endtask

    task automatic chk_log(input int k, input bit we, input logic [31:0] a, input string rq);
        if (k >= blog.size()) chk(1'b0, rq, 32'hFFFF_FFFF, a);
        else chk(blog[k] == {we, a}, rq, blog[k][31:0] | (32'(blog[k][32]) << 31), a | (32'(we) << 31));
    endtask

    function automatic logic [127:0] mk_line(input logic [31:0] base);
        return {base + 32'd3, base + 32'd2, base + 32'd1, base};
    endfunction

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) begin
            mem_bus[k] = 32'hA000_0000 + 32'(k);
            gold[k]    = 32'hA000_0000 + 32'(k);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!bus_valid && !i_done && !d_done && !i_rvalid && !d_rvalid, "R1 reset idle",
            {27'd0, bus_valid, i_done, d_done, i_rvalid, d_rvalid}, 32'd0);

        // R2 single read
        blog.delete();
        do_req(1'b0, 2'b00, 32'h104, 1'b0, '0);
        settle();
        chk(blog.size() == 1, "R2 one beat", blog.size(), 1);
        chk_log(0, 1'b0, 32'h104, "R2 read address");

        // R3 line fill
        blog.delete();
        do_req(1'b0, 2'b10, 32'h208, 1'b0, '0);
        settle();
        for (int k = 0; k < 4; k++) chk_log(k, 1'b0, 32'h200 + 32'(4*k), "R3 fill beat order");

        // R4 single write
        blog.delete();
        do_req(1'b1, 2'b01, 32'h308, 1'b0, {96'd0, 32'h5555_0001});
        settle();
        chk(blog.size() == 1, "R4 one beat", blog.size(), 1);
        chk_log(0, 1'b1, 32'h308, "R4 write address");

        // R5 write-back taken quietly, drained later
        blog.delete();
        do_req(1'b1, 2'b11, 32'h040, 1'b0, mk_line(32'hB000_0040));
        chk(blog.size() == 0 && !bus_valid, "R5 done before bus beat", blog.size(), 0);
        settle();
        for (int k = 0; k < 4; k++) chk_log(k, 1'b1, 32'h040 + 32'(4*k), "R5 drain beats");

        // R7 first tie goes to data side
        blog.delete();
        fork
            do_req(1'b0, 2'b00, 32'h010, 1'b0, '0);
            do_req(1'b1, 2'b00, 32'h020, 1'b0, '0);
        join
        settle();
        chk_log(0, 1'b0, 32'h020, "R7 first tie data");

        // R7 second tie alternates
        blog.delete();
        fork
            do_req(1'b0, 2'b00, 32'h014, 1'b0, '0);
            do_req(1'b1, 2'b00, 32'h024, 1'b0, '0);
        join
        settle();
        chk_log(0, 1'b0, 32'h014, "R7 second tie instr");

        // R6 read ahead of write
        blog.delete();
        fork
            do_req(1'b1, 2'b01, 32'h030, 1'b0, {96'd0, 32'hC0DE_0030});
            do_req(1'b0, 2'b00, 32'h034, 1'b0, '0);
        join
        settle();
        chk_log(0, 1'b0, 32'h034, "R6 read first");

        // R10 I/O write not overtaken
        blog.delete();
        fork
            do_req(1'b1, 2'b01, 32'h038, 1'b1, {96'd0, 32'hD0D0_0038});
            do_req(1'b0, 2'b00, 32'h03C, 1'b0, '0);
        join
        settle();
        chk_log(0, 1'b1, 32'h038, "R10 io write first");

        // R8 + R6: fill not preempted, read before drain
        ack_gap = 2;
        blog.delete();
        fork
            do_req(1'b0, 2'b10, 32'h100, 1'b0, '0);
            begin
                repeat (3) @(negedge clk);
                do_req(1'b1, 2'b11, 32'h180, 1'b0, mk_line(32'hE000_0180));
                do_req(1'b1, 2'b00, 32'h284, 1'b0, '0);
            end
        join
        settle();
        for (int k = 0; k < 4; k++) chk_log(k, 1'b0, 32'h100 + 32'(4*k), "R8 fill contiguous");
        chk_log(4, 1'b0, 32'h284, "R6 read before drain");
        chk_log(5, 1'b1, 32'h180, "R6 drain after read");

        // R9 conflicting read waits for drain
        blog.delete();
        fork
            do_req(1'b0, 2'b10, 32'h300, 1'b0, '0);
            begin
                repeat (3) @(negedge clk);
                do_req(1'b1, 2'b11, 32'h080, 1'b0, mk_line(32'hF000_0080));
                do_req(1'b1, 2'b00, 32'h088, 1'b0, '0);
            end
        join
        settle();
        chk_log(4, 1'b1, 32'h080, "R9 drain first");
        chk_log(8, 1'b0, 32'h088, "R9 read after drain");

        // R10 I/O read waits for drain
        blog.delete();
        fork
            do_req(1'b0, 2'b10, 32'h340, 1'b0, '0);
            begin
                repeat (3) @(negedge clk);
                do_req(1'b1, 2'b11, 32'h0C0, 1'b0, mk_line(32'h1234_00C0));
                do_req(1'b1, 2'b00, 32'h3F0, 1'b1, '0);
            end
        join
        settle();
        chk_log(4, 1'b1, 32'h0C0, "R10 drain before io");
        chk_log(8, 1'b0, 32'h3F0, "R10 io after drain");

        // final memory image (R4, R5) and no leftover expected reads (R3)
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 256; k++) if (mem_bus[k] !== gold[k]) bad++;
            chk(bad == 0, "R4/R5 memory image", bad, 0);
        end
        chk(exp_i.size() == 0 && exp_d.size() == 0, "R3 all reads returned",
            exp_i.size() + exp_d.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule